// File: doc/BRIEF.md
# Synthesizer Programming Port

This block is the control interface of an integer-N frequency synthesizer. It takes a slow three-wire serial port (data, shift clock, and two strobes) and a set of parallel counter pins. From these it produces the divider values for the main counter (M), the swallow counter (A) and the reference counter (R), together with the enhancement control flags. It also provides a test-output selector that routes one internal divider signal to a single debug pin.

The serial port holds two independent shift buffers, and the level of the enhancement-select strobe chooses which one receives data. The 20-bit frequency buffer is copied into its register on the rising edge of the frequency-write strobe. The 8-bit enhancement buffer is copied on the falling edge of the enhancement-select strobe itself. All serial inputs are brought into a fast system clock through two-flop synchronizers, and their edges are detected in that domain. The system clock must run at least four times faster than the serial clock, which is at most 10 MHz. When direct mode is selected, the counter fields come straight from the parallel pins and the register contents are ignored.

Top module: `synth_prog_port`

## Requirements
- R1: After reset, in serial mode with the enhancement gate open, m_val, a_val and r_val are 0, pb_en, pwr_down and cnt_load are 0, and dout is 0.
- R2: While enh_sel is low, each rising edge of ser_clk shifts ser_data into the frequency buffer, with the first bit landing in bit 0 after 20 shifts. The frequency register, and with it the serial m_val, a_val and r_val, changes only on a rising edge of freq_wr.
- R3: Frequency word bit positions b0..b19 map to R5, R4, M8, M7, reserved (write 0), M6, M5, M4, M3, M2, M1, M0, R3, R2, R1, R0, A3, A2, A1, A0.
- R4: While enh_sel is high, ser_clk rising edges shift ser_data into a separate 8-bit buffer, first bit ending in b0. That buffer is copied to the enhancement register on the falling edge of enh_sel.
- R5: Enhancement bits are b2 = route fp to dout, b3 = power-down, b4 = counter load, b5 = route msel to dout, b6 = route fc to dout, b7 = prescaler bypass, and b0/b1 are reserved. All are active high, and all take effect only while enh_n is low. Otherwise they read as 0.
- R6: When dir_mode is high, m_val, a_val and r_val equal pin_m, pin_a and pin_r, and pb_en is 0 whatever the enhancement register holds.
- R7: dout carries fp_in if b2 is effective, else fc_in if b6 is effective, else msel_in if b5 is effective, else 0.
- R8: Loading one register leaves the other unchanged. Shifts with enh_sel low do not alter the enhancement register, and a freq_wr strobe does not alter it either.
- R9: If more than 20 bits are shifted before freq_wr, the last 20 bits shifted are the ones committed.
- R10: With power-down effective, pwr_down is 1 and the serial port still loads the frequency register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data, LSB first |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| freq_wr | input | 1 | Frequency register commit strobe (rising edge) |
| enh_sel | input | 1 | High selects the enhancement buffer; its falling edge commits it |
| dir_mode | input | 1 | 1 = direct pin mode, 0 = serial mode |
| enh_n | input | 1 | Active-low gate for enhancement bits |
| pin_m | input | 9 | Direct-mode M value |
| pin_a | input | 4 | Direct-mode A value |
| pin_r | input | 6 | Direct-mode R value |
| fp_in | input | 1 | Main counter output for the test selector |
| fc_in | input | 1 | Reference counter output for the test selector |
| msel_in | input | 1 | Modulus select for the test selector |
| m_val | output | 9 | Active M counter value |
| a_val | output | 4 | Active A counter value |
| r_val | output | 6 | Active R counter value |
| pb_en | output | 1 | Prescaler bypass enable |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Immediate, continuous counter load |
| dout | output | 1 | Test output |

## Verification
The assertions assume that ser_clk, freq_wr and enh_sel each hold every level for at least two system clocks. They also assume ser_data is steady for a couple of system clocks on either side of a ser_clk rise, and that enh_sel does not change in the same system clock as a ser_clk or freq_wr edge. The bench drives every serial input change and then holds the new level for four system clocks, so the synchronizers always see clean, ordered edges. dir_mode and the parallel pins are treated as quasi-static, and the bench only changes them between scenarios.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
// Shared widths and enhancement bit positions for the synthesizer programming port.
package synth_prog_pkg;
    localparam int FREQ_W = 20;
    localparam int ENH_W  = 8;
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int R_W    = 6;
    // Enhancement bit positions (decoded by the control logic)
    localparam int EB_FP  = 2;
    localparam int EB_PD  = 3;
    localparam int EB_LD  = 4;
    localparam int EB_MS  = 5;
    localparam int EB_FC  = 6;
    localparam int EB_PB  = 7;

    typedef struct packed {
        logic pb;
        logic fc_out;
        logic ms_out;
        logic load;
        logic pdown;
        logic fp_out;
    } enh_ctl_t;
endpackage

// File: rtl/prog_sync.sv
`timescale 1ns/1ps
// prog_sync: multi-stage synchronizer with rise/fall detection per bit.
// Assumes every input level lasts at least two clk cycles.
module prog_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             prev;

    // Shift the asynchronous inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/prog_shift.sv
`timescale 1ns/1ps
// prog_shift: two LSB-first shift buffers selected by the enhancement strobe
// level, each committed to its register on its own strobe edge.
// Assumes synchronized inputs from prog_sync.
module prog_shift
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdat,
    input  logic              sclk_rise,
    input  logic              ew_lvl,
    input  logic              ew_fall,
    input  logic              sw_rise,
    output logic [FREQ_W-1:0] freq_q,
    output logic [ENH_W-1:0]  enh_q
);
    logic [FREQ_W-1:0] fbuf;
    logic [ENH_W-1:0]  ebuf;

    // Frequency buffer shifts while the enhancement strobe is low
    always_ff @(posedge clk) begin
        if (!rst_n)                    fbuf <= '0;
        else if (sclk_rise && !ew_lvl) fbuf <= {sdat, fbuf[FREQ_W-1:1]};
    end

    // Enhancement buffer shifts while the enhancement strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n)                   ebuf <= '0;
        else if (sclk_rise && ew_lvl) ebuf <= {sdat, ebuf[ENH_W-1:1]};
    end

    // Commit the frequency buffer on the write strobe rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)       freq_q <= '0;
        else if (sw_rise) freq_q <= fbuf;
    end

    // Commit the enhancement buffer on the enhancement strobe falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)       enh_q <= '0;
        else if (ew_fall) enh_q <= ebuf;
    end

    p_freq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rise |=> $stable(freq_q));
    p_enh_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ew_fall |=> $stable(enh_q));
    p_ebuf_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !ew_lvl) |=> $stable(ebuf));
    p_fbuf_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && ew_lvl) |=> $stable(fbuf));
endmodule

// File: rtl/prog_decode.sv
`timescale 1ns/1ps
// prog_decode: unpacks the frequency word, applies the direct-pin override,
// gates the enhancement bits and drives the prioritized test output.
// Purely combinational; assumes dir_mode and pins are quasi-static.
module prog_decode
    import synth_prog_pkg::*;
(
    input  logic [FREQ_W-1:0] freq_q,
    input  logic [ENH_W-1:0]  enh_q,
    input  logic              dir_mode,
    input  logic              enh_n,
    input  logic [M_W-1:0]    pin_m,
    input  logic [A_W-1:0]    pin_a,
    input  logic [R_W-1:0]    pin_r,
    input  logic              fp_in,
    input  logic              fc_in,
    input  logic              msel_in,
    output logic [M_W-1:0]    m_val,
    output logic [A_W-1:0]    a_val,
    output logic [R_W-1:0]    r_val,
    output enh_ctl_t          ctl,
    output logic              dout
);
    logic [M_W-1:0] ser_m;
    logic [A_W-1:0] ser_a;
    logic [R_W-1:0] ser_r;

    // Fixed serial bit-to-field map
    assign ser_r = {freq_q[0], freq_q[1], freq_q[12], freq_q[13], freq_q[14], freq_q[15]};
    assign ser_m = {freq_q[2], freq_q[3], freq_q[5], freq_q[6], freq_q[7],
                    freq_q[8], freq_q[9], freq_q[10], freq_q[11]};
    assign ser_a = {freq_q[16], freq_q[17], freq_q[18], freq_q[19]};

    // Select counter fields from the pins or the register
    always_comb begin
        if (dir_mode) begin
            m_val = pin_m;
            a_val = pin_a;
            r_val = pin_r;
        end else begin
            m_val = ser_m;
            a_val = ser_a;
            r_val = ser_r;
        end
    end

    // Gate enhancement bits; bypass is never allowed in direct mode
    always_comb begin
        ctl        = '0;
        if (!enh_n) begin
            ctl.fp_out = enh_q[EB_FP];
            ctl.pdown  = enh_q[EB_PD];
            ctl.load   = enh_q[EB_LD];
            ctl.ms_out = enh_q[EB_MS];
            ctl.fc_out = enh_q[EB_FC];
            ctl.pb     = enh_q[EB_PB] & ~dir_mode;
        end
    end

    // Test output selector with fixed priority fp, fc, msel
    always_comb begin
        if (ctl.fp_out)      dout = fp_in;
        else if (ctl.fc_out) dout = fc_in;
        else if (ctl.ms_out) dout = msel_in;
        else                 dout = 1'b0;
    end
endmodule

// File: rtl/synth_prog_port.sv
`timescale 1ns/1ps
// synth_prog_port: serial/direct programming port of the synthesizer.
// Assumes clk is at least 4x the serial clock and that serial input levels
// each last two or more clk cycles.
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_data,
    input  logic           ser_clk,
    input  logic           freq_wr,
    input  logic           enh_sel,
    input  logic           dir_mode,
    input  logic           enh_n,
    input  logic [M_W-1:0] pin_m,
    input  logic [A_W-1:0] pin_a,
    input  logic [R_W-1:0] pin_r,
    input  logic           fp_in,
    input  logic           fc_in,
    input  logic           msel_in,
    output logic [M_W-1:0] m_val,
    output logic [A_W-1:0] a_val,
    output logic [R_W-1:0] r_val,
    output logic           pb_en,
    output logic           pwr_down,
    output logic           cnt_load,
    output logic           dout
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0]  s_lvl, s_rise, s_fall;
    logic [FREQ_W-1:0] freq_q;
    logic [ENH_W-1:0]  enh_q;
    enh_ctl_t          ctl;

    // Bit order: 3 = data, 2 = shift clock, 1 = freq strobe, 0 = enh strobe
    prog_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_data, ser_clk, freq_wr, enh_sel}),
        .lvl      (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    prog_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdat      (s_lvl[3]),
        .sclk_rise (s_rise[2]),
        .ew_lvl    (s_lvl[0]),
        .ew_fall   (s_fall[0]),
        .sw_rise   (s_rise[1]),
        .freq_q    (freq_q),
        .enh_q     (enh_q)
    );

    prog_decode u_dec (
        .freq_q   (freq_q),
        .enh_q    (enh_q),
        .dir_mode (dir_mode),
        .enh_n    (enh_n),
        .pin_m    (pin_m),
        .pin_a    (pin_a),
        .pin_r    (pin_r),
        .fp_in    (fp_in),
        .fc_in    (fc_in),
        .msel_in  (msel_in),
        .m_val    (m_val),
        .a_val    (a_val),
        .r_val    (r_val),
        .ctl      (ctl),
        .dout     (dout)
    );

    assign pb_en    = ctl.pb;
    assign pwr_down = ctl.pdown;
    assign cnt_load = ctl.load;

    p_dir_nobypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dir_mode |-> !pb_en);
    p_enh_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n |-> (!pb_en && !pwr_down && !cnt_load && !dout));
    p_dout_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_in && !fc_in && !msel_in) |-> !dout);
    p_dir_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dir_mode |-> (m_val == pin_m && a_val == pin_a && r_val == pin_r));
endmodule

// File: tb/sim_synth_prog_port.sv
`timescale 1ns/1ps
// Directed bench for synth_prog_port; each scenario task checks its own results.
module sim_synth_prog_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0, ser_clk = 1'b0, freq_wr = 1'b0, enh_sel = 1'b0;
    logic       dir_mode = 1'b0, enh_n = 1'b0;
    logic [8:0] pin_m = '0;
    logic [3:0] pin_a = '0;
    logic [5:0] pin_r = '0;
    logic       fp_in = 1'b0, fc_in = 1'b0, msel_in = 1'b0;
    logic [8:0] m_val;
    logic [3:0] a_val;
    logic [5:0] r_val;
    logic       pb_en, pwr_down, cnt_load, dout;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    synth_prog_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .freq_wr(freq_wr), .enh_sel(enh_sel), .dir_mode(dir_mode), .enh_n(enh_n),
        .pin_m(pin_m), .pin_a(pin_a), .pin_r(pin_r),
        .fp_in(fp_in), .fc_in(fc_in), .msel_in(msel_in),
        .m_val(m_val), .a_val(a_val), .r_val(r_val),
        .pb_en(pb_en), .pwr_down(pwr_down), .cnt_load(cnt_load), .dout(dout)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Build a frequency word from fields per the R3 map
    function automatic logic [19:0] enc(input logic [8:0] m, input logic [3:0] a, input logic [5:0] r);
        logic [19:0] w;
        w = '0;
        w[0] = r[5]; w[1] = r[4]; w[2] = m[8]; w[3] = m[7]; w[4] = 1'b0;
        for (int k = 0; k < 7; k++) w[5+k]  = m[6-k];
        for (int k = 0; k < 4; k++) w[12+k] = r[3-k];
        for (int k = 0; k < 4; k++) w[16+k] = a[3-k];
        return w;
    endfunction

    task automatic send_bit(input logic b);
        ser_data = b; tick(4);
        ser_clk = 1'b1; tick(4);
        ser_clk = 1'b0; tick(4);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic pulse_wr();
        freq_wr = 1'b1; tick(4);
        freq_wr = 1'b0; tick(6);
    endtask

    task automatic load_freq(input logic [19:0] w);
        shift_bits({12'd0, w}, 20);
        pulse_wr();
    endtask

    task automatic load_enh(input logic [7:0] e);
        enh_sel = 1'b1; tick(4);
        shift_bits({24'd0, e}, 8);
        enh_sel = 1'b0; tick(6);
    endtask

    task automatic t_reset();
        chk("R1 m", m_val, 0); chk("R1 a", a_val, 0); chk("R1 r", r_val, 0);
        chk("R1 flags", {pb_en, pwr_down, cnt_load}, 0);
        chk("R1 dout", dout, 0);
    endtask

    task automatic t_serial_load();
        shift_bits({12'd0, enc(9'h1A5, 4'h9, 6'h2C)}, 20);
        chk("R2 no commit before strobe", m_val, 0);
        pulse_wr();
        chk("R2 m", m_val, 9'h1A5); chk("R3 a", a_val, 4'h9); chk("R3 r", r_val, 6'h2C);
        load_freq(enc(9'h05A, 4'h6, 6'h13));
        chk("R3 m2", m_val, 9'h05A); chk("R3 a2", a_val, 4'h6); chk("R3 r2", r_val, 6'h13);
        load_freq(enc(9'h100, 4'h8, 6'h20));
        chk("R3 msb m", m_val, 9'h100); chk("R3 msb a", a_val, 4'h8); chk("R3 msb r", r_val, 6'h20);
    endtask

    task automatic t_overlong();
        shift_bits(32'h1F, 5);
        load_freq(enc(9'h0C3, 4'h1, 6'h05));
        chk("R9 m", m_val, 9'h0C3); chk("R9 a", a_val, 4'h1); chk("R9 r", r_val, 6'h05);
    endtask

    task automatic t_enh_gate();
        load_enh(8'h98);
        chk("R4 pb", pb_en, 1); chk("R5 pd", pwr_down, 1); chk("R5 load", cnt_load, 1);
        chk("R8 freq kept", m_val, 9'h0C3);
        enh_n = 1'b1; tick(2);
        chk("R5 gated", {pb_en, pwr_down, cnt_load}, 0);
        enh_n = 1'b0; tick(2);
        load_freq(enc(9'h0AA, 4'h2, 6'h0F));
        chk("R8 enh kept", {pb_en, pwr_down, cnt_load}, 3'b111);
        chk("R10 pd load m", m_val, 9'h0AA);
        load_enh(8'h10);
        chk("R4 reload", {pb_en, pwr_down, cnt_load}, 3'b001);
    endtask

    task automatic t_direct();
        load_enh(8'h80);
        chk("R5 pb serial", pb_en, 1);
        pin_m = 9'h1F0; pin_a = 4'hC; pin_r = 6'h3A;
        dir_mode = 1'b1; tick(2);
        chk("R6 m", m_val, 9'h1F0); chk("R6 a", a_val, 4'hC); chk("R6 r", r_val, 6'h3A);
        chk("R6 pb off", pb_en, 0);
        dir_mode = 1'b0; tick(2);
        chk("R6 back to reg", m_val, 9'h0AA);
    endtask

    task automatic t_dout();
        load_enh(8'h44);
        fp_in = 1'b1; fc_in = 1'b0; tick(1); chk("R7 fp wins 1", dout, 1);
        fp_in = 1'b0; fc_in = 1'b1; tick(1); chk("R7 fp wins 0", dout, 0);
        load_enh(8'h60);
        msel_in = 1'b1; fc_in = 1'b0; tick(1); chk("R7 fc over msel", dout, 0);
        fc_in = 1'b1; tick(1); chk("R7 fc", dout, 1);
        load_enh(8'h20);
        fc_in = 1'b0; tick(1); chk("R7 msel", dout, 1);
        load_enh(8'h00);
        fp_in = 1'b1; fc_in = 1'b1; tick(1); chk("R7 none", dout, 0);
        fp_in = 1'b0; fc_in = 1'b0; msel_in = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_serial_load();
        t_overlong();
        t_enh_gate();
        t_direct();
        t_dout();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule